// File: doc/BRIEF.md
# Prioritizing Interrupt Controller

This block gathers interrupt requests from eight sources and presents one interrupt line to a processor. Each source can be programmed as edge-sensitive or level-sensitive. A request waits in a pending register until it is acknowledged. It then moves into an in-service register, where it stays until an end-of-interrupt command completes it. A mask register hides sources from the processor. Priority between sources is either fixed or rotating. The rotating order moves each time a source finishes.

A narrow configuration write port (`cfg_we`, `cfg_addr`, `cfg_wdata`) sets up the block and also issues completion commands. Address 0 holds the mask, where a 1 hides the source. Address 1 holds the trigger select, where a 1 makes the source level-sensitive. Address 2 is the control word: bits [4:0] hold the vector base, bit 5 enables rotating priority and bit 6 enables automatic completion. A write to address 3 is a completion command. If bit 7 of that write is 1, it clears the in-service bit named by bits [2:0]. If bit 7 is 0, it clears the highest-priority bit that is in service.

The sequencing is a two-state machine. In `ST_IDLE` the line is low. The transition idle→raise happens when the best visible pending request outranks everything in service. In `ST_RAISE` the line is high. The transition raise→idle happens either when an acknowledge is accepted or when the request is withdrawn (released, masked, or outranked). After an accepted acknowledge, the block always spends at least one cycle in `ST_IDLE`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_o`, `vec_valid_o` and `vec_o` are 0. All sources are unmasked and edge-sensitive, priority is fixed, automatic completion is off and the vector base is 0.
- R2: A rising edge on an edge-sensitive source makes the request pending. Keeping that input high after it has been acknowledged raises no further request.
- R3: For a level-sensitive source, the pending state follows the input. If the input is released before acknowledge, `int_o` falls again. If it is still high after completion, the source is presented again.
- R4: A masked source is never presented and never acknowledged. An edge it received while masked is presented once the mask bit is cleared.
- R5: With fixed priority, source 0 ranks highest and source 7 lowest.
- R6: An acknowledge accepted while `int_o` is high produces a one-cycle `vec_valid_o` pulse on the next cycle, with `vec_o` = base×8 + winning index. An acknowledge while `int_o` is low is ignored.
- R7: On an accepted acknowledge, `int_o` falls on the next cycle. The winner's pending bit is cleared and its in-service bit is set.
- R8: `int_o` rises only when the best unmasked pending request ranks strictly above every in-service source, so a higher-priority request can nest.
- R9: A specific completion command (address 3, bit 7 = 1) clears the in-service bit given by bits [2:0].
- R10: A non-specific completion command (address 3, bit 7 = 0) clears the highest-ranked in-service bit under the current priority order.
- R11: With automatic completion (control bit 6), the acknowledge leaves no in-service bit set, so the next request is presented without any command.
- R12: With rotating priority (control bit 5), the source that has just completed becomes the lowest rank, and the source one index above it becomes the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Raw request inputs, synchronized inside the block |
| cfg_we | input | 1 | Configuration/command write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 trigger, 2 control, 3 completion command |
| cfg_wdata | input | 8 | Write data |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| int_o | output | 1 | Interrupt line to the processor |
| vec_valid_o | output | 1 | One-cycle pulse: `vec_o` holds a new vector |
| vec_o | output | 8 | Vector of the acknowledged source |

## Verification
The two internal registers that can go wrong without showing at once are the in-service set and the rotation pointer. A stale in-service bit keeps `int_o` low for a lower-ranked pending source for as long as it stays set. A wrongly cleared bit lets such a source raise `int_o` four cycles after its edge. A wrong rotation pointer shows up as a wrong index in `vec_o` at the next acknowledge where two sources compete. The bench runs a cycle-by-cycle reference model alongside the design and compares `int_o`, `vec_valid_o` and `vec_o` on every clock. Every such divergence is therefore caught in the cycle where it first reaches a port.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } irq_state_e;

    localparam logic [1:0] CFG_MASK = 2'd0;
    localparam logic [1:0] CFG_TRIG = 2'd1;
    localparam logic [1:0] CFG_CTRL = 2'd2;
    localparam logic [1:0] CFG_EOI  = 2'd3;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] level_i,
    input  logic [N_IRQ-1:0] clr_i,
    output logic [N_IRQ-1:0] pend_o
);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        // [0] first sync stage, [1] synced level, [2] previous synced level
        logic [2:0] sync_q;
        logic       pend_q;
        logic       rise;

        assign rise = sync_q[1] & ~sync_q[2];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
                pend_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[1:0], irq_i[g]};
                if (level_i[g]) begin
                    pend_q <= sync_q[1];
                end else begin
                    pend_q <= (pend_q & ~clr_i[g]) | rise;
                end
            end
        end

        assign pend_o[g] = pend_q;
    end

endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req_i,
    input  logic [IDX_W-1:0] low_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] rank_o
);

    logic [IDX_W-1:0] cand;

    // rank r belongs to index low_i + 1 + r (wrapping); rank 0 is the highest
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        rank_o = '0;
        cand   = '0;
        for (int r = N_IRQ - 1; r >= 0; r--) begin
            cand = low_i + IDX_W'(1) + IDX_W'(r);
            if (req_i[cand]) begin
                hit_o  = 1'b1;
                idx_o  = cand;
                rank_o = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int BASE_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_IRQ-1:0]                irq_i,
    input  logic                            cfg_we,
    input  logic [1:0]                      cfg_addr,
    input  logic [N_IRQ-1:0]                cfg_wdata,
    input  logic                            ack_i,
    output logic                            int_o,
    output logic                            vec_valid_o,
    output logic [BASE_W+$clog2(N_IRQ)-1:0] vec_o
);

    localparam int IDX_W    = $clog2(N_IRQ);
    localparam int VEC_W    = BASE_W + IDX_W;
    localparam int ROT_BIT  = BASE_W;
    localparam int AEOI_BIT = BASE_W + 1;
    localparam int SPEC_BIT = N_IRQ - 1;

    logic [N_IRQ-1:0]  mask_q, level_q, isr_q, pend, clr_pend, isr_clr, isr_set;
    logic [BASE_W-1:0] base_q;
    logic              rot_q, aeoi_q;
    logic [IDX_W-1:0]  low_q, low_eff;
    irq_state_e        state_q, state_d;
    logic              cand_hit, isr_hit, take, accept, eoi_wr, eoi_hit;
    logic [IDX_W-1:0]  cand_idx, cand_rank, isr_idx, isr_rank, eoi_idx;
    logic              vec_valid_q;
    logic [VEC_W-1:0]  vec_q;

    irq_req_capture #(.N_IRQ(N_IRQ)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .level_i(level_q),
        .clr_i  (clr_pend),
        .pend_o (pend)
    );

    assign low_eff = rot_q ? low_q : IDX_W'(N_IRQ - 1);

    irq_rank_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick_pend (
        .req_i (pend & ~mask_q),
        .low_i (low_eff),
        .hit_o (cand_hit),
        .idx_o (cand_idx),
        .rank_o(cand_rank)
    );

    irq_rank_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick_isr (
        .req_i (isr_q),
        .low_i (low_eff),
        .hit_o (isr_hit),
        .idx_o (isr_idx),
        .rank_o(isr_rank)
    );

    assign take    = cand_hit && (!isr_hit || (cand_rank < isr_rank));
    assign accept  = ack_i && (state_q == ST_RAISE) && take;
    assign eoi_wr  = cfg_we && (cfg_addr == CFG_EOI);
    assign eoi_idx = cfg_wdata[SPEC_BIT] ? cfg_wdata[IDX_W-1:0] : isr_idx;
    assign eoi_hit = eoi_wr && (cfg_wdata[SPEC_BIT] ? isr_q[cfg_wdata[IDX_W-1:0]] : isr_hit);

    assign isr_clr  = eoi_hit ? (N_IRQ'(1) << eoi_idx) : '0;
    assign isr_set  = (accept && !aeoi_q) ? (N_IRQ'(1) << cand_idx) : '0;
    assign clr_pend = accept ? (N_IRQ'(1) << cand_idx) : '0;

    // configuration, in-service set and rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
            base_q  <= '0;
            rot_q   <= 1'b0;
            aeoi_q  <= 1'b0;
            isr_q   <= '0;
            low_q   <= IDX_W'(N_IRQ - 1);
        end else begin
            if (cfg_we && cfg_addr == CFG_MASK) mask_q <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_TRIG) level_q <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_CTRL) begin
                base_q <= cfg_wdata[BASE_W-1:0];
                rot_q  <= cfg_wdata[ROT_BIT];
                aeoi_q <= cfg_wdata[AEOI_BIT];
            end
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (rot_q) begin
                if (eoi_hit) begin
                    low_q <= eoi_idx;
                end else if (accept && aeoi_q) begin
                    low_q <= cand_idx;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_RAISE;
            ST_RAISE: if (accept || !take) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid_q <= 1'b0;
            vec_q       <= '0;
        end else begin
            vec_valid_q <= accept;
            if (accept) vec_q <= {base_q, cand_idx};
        end
    end

    always_comb begin
        int_o       = (state_q == ST_RAISE);
        vec_valid_o = vec_valid_q;
        vec_o       = vec_q;
    end

    p_masked_never_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !mask_q[cand_idx]);

    p_vector_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(int_o && ack_i));

    p_line_drops_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i) |=> !int_o);

    p_specific_eoi_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && cfg_wdata[SPEC_BIT] && !accept) |=> !isr_q[$past(cfg_wdata[IDX_W-1:0])]);

    p_auto_eoi_leaves_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && aeoi_q) |=> !isr_q[$past(cand_idx)]);

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ack_i = 1'b0;
    logic       int_o, vec_valid_o;
    logic [7:0] vec_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack_i(ack_i),
        .int_o(int_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    // ---------------- behavioural reference model ----------------
    bit m_s1[8], m_s2[8], m_s3[8], m_pend[8], m_isr[8], m_mask[8], m_lvl[8];
    bit n_pend[8], n_isr[8];
    int m_base, m_low, m_vec;
    bit m_rot, m_aeoi, m_raise, m_vv;
    int lo, ci, cr, ii, ir, eoi_i, idx;
    bit take, acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin
                m_s1[k] = 0; m_s2[k] = 0; m_s3[k] = 0; m_pend[k] = 0;
                m_isr[k] = 0; m_mask[k] = 0; m_lvl[k] = 0;
            end
            m_base = 0; m_low = 7; m_vec = 0; m_rot = 0; m_aeoi = 0;
            m_raise = 0; m_vv = 0;
        end else begin
            lo = m_rot ? m_low : 7;
            ci = -1; cr = 8; ii = -1; ir = 8;
            for (int r = 0; r < 8; r++) begin
                idx = (lo + 1 + r) % 8;
                if (ci < 0 && m_pend[idx] && !m_mask[idx]) begin ci = idx; cr = r; end
                if (ii < 0 && m_isr[idx]) begin ii = idx; ir = r; end
            end
            take = (ci >= 0) && (ii < 0 || cr < ir);
            acc = ack_i && m_raise && take;
            eoi_i = -1;
            if (cfg_we && cfg_addr == 2'd3) begin
                if (cfg_wdata[7]) begin
                    if (m_isr[cfg_wdata[2:0]]) eoi_i = int'(cfg_wdata[2:0]);
                end else begin
                    eoi_i = ii;
                end
            end
            for (int k = 0; k < 8; k++) begin
                n_isr[k] = m_isr[k];
                if (m_lvl[k]) n_pend[k] = m_s2[k];
                else n_pend[k] = (m_pend[k] && !(acc && ci == k)) || (m_s2[k] && !m_s3[k]);
            end
            if (eoi_i >= 0) n_isr[eoi_i] = 0;
            if (acc && !m_aeoi) n_isr[ci] = 1;
            if (m_rot) begin
                if (eoi_i >= 0) m_low = eoi_i;
                else if (acc && m_aeoi) m_low = ci;
            end
            m_vv = acc;
            if (acc) m_vec = m_base * 8 + ci;
            m_raise = take && !acc;
            for (int k = 0; k < 8; k++) begin
                m_pend[k] = n_pend[k];
                m_isr[k]  = n_isr[k];
                m_s3[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = irq_i[k];
            end
            if (cfg_we && cfg_addr == 2'd0) for (int k = 0; k < 8; k++) m_mask[k] = cfg_wdata[k];
            if (cfg_we && cfg_addr == 2'd1) for (int k = 0; k < 8; k++) m_lvl[k] = cfg_wdata[k];
            if (cfg_we && cfg_addr == 2'd2) begin
                m_base = int'(cfg_wdata[4:0]); m_rot = cfg_wdata[5]; m_aeoi = cfg_wdata[6];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int_o == m_raise, "R8 model int_o", int'(int_o), int'(m_raise));
            chk(vec_valid_o == m_vv, "R6 model vec_valid_o", int'(vec_valid_o), int'(m_vv));
            chk(int'(vec_o) == m_vec, "R6 model vec_o", int'(vec_o), m_vec);
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] bits);
        irq_i = irq_i | bits;
        repeat (3) @(negedge clk);
        irq_i = irq_i & ~bits;
    endtask

    task automatic wait_int(input string tag);
        int n = 0;
        while (!int_o && n < 30) begin @(negedge clk); n++; end
        chk(int_o, tag, int'(int_o), 1);
    endtask

    task automatic ack_chk(input int exp, input string tag);
        wait_int(tag);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk(vec_valid_o && int'(vec_o) == exp, tag, int'(vec_o), exp);
        chk(!int_o, "R7 int_o low after ack", int'(int_o), 0);
    endtask

    task automatic quiet_chk(input int n, input string tag);
        repeat (n) @(negedge clk);
        chk(!int_o, tag, int'(int_o), 0);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog: run hung, cycles=%0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!int_o, "R1 int_o reset", int'(int_o), 0);
        chk(!vec_valid_o, "R1 vec_valid_o reset", int'(vec_valid_o), 0);
        chk(vec_o == 8'd0, "R1 vec_o reset", int'(vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_write(2'd2, 8'h05);                 // base 5, fixed, no auto
        // R2 edge capture, held input does not re-request
        irq_i[3] = 1'b1;
        ack_chk(43, "R2 edge source 3 vector");
        cfg_write(2'd3, 8'h00);
        quiet_chk(10, "R2 held edge input no re-request");
        irq_i[3] = 1'b0;
        @(negedge clk);

        // R5 fixed priority, R8 blocking, R10 non-specific
        pulse(8'h44);
        ack_chk(42, "R5 fixed priority picks source 2");
        quiet_chk(8, "R8 lower source blocked by in-service");
        cfg_write(2'd3, 8'h00);
        ack_chk(46, "R10 non-specific EOI releases source 6");
        cfg_write(2'd3, 8'h00);

        // R8 nesting, R10 highest-first, R9 specific
        pulse(8'h20);
        ack_chk(45, "R6 vector source 5");
        pulse(8'h40);
        quiet_chk(6, "R8 source 6 blocked by 5");
        pulse(8'h02);
        ack_chk(41, "R8 nested source 1");
        cfg_write(2'd3, 8'h00);
        quiet_chk(6, "R10 non-specific cleared 1 not 5");
        cfg_write(2'd3, 8'h85);
        ack_chk(46, "R9 specific EOI of 5");
        cfg_write(2'd3, 8'h86);

        // R4 mask, R6 ignored ack
        cfg_write(2'd0, 8'h10);
        pulse(8'h10);
        quiet_chk(8, "R4 masked source not presented");
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk(!vec_valid_o, "R6 ack while idle ignored", int'(vec_valid_o), 0);
        cfg_write(2'd0, 8'h00);
        ack_chk(44, "R4 unmasked edge presented");
        cfg_write(2'd3, 8'h00);

        // R3 level mode
        cfg_write(2'd1, 8'h01);
        irq_i[0] = 1'b1;
        wait_int("R3 level source raises");
        irq_i[0] = 1'b0;
        quiet_chk(6, "R3 level released withdraws");
        irq_i[0] = 1'b1;
        ack_chk(40, "R3 level source vector");
        cfg_write(2'd3, 8'h00);
        wait_int("R3 level still high re-presented");
        irq_i[0] = 1'b0;
        quiet_chk(6, "R3 level release after re-present");
        cfg_write(2'd1, 8'h00);

        // R11 automatic completion
        cfg_write(2'd2, 8'h45);
        pulse(8'h44);
        ack_chk(42, "R11 auto EOI first");
        ack_chk(46, "R11 auto EOI next without command");
        cfg_write(2'd2, 8'h05);

        // R12 rotating priority
        cfg_write(2'd2, 8'h25);
        pulse(8'h04);
        ack_chk(42, "R12 rotate setup source 2");
        cfg_write(2'd3, 8'h00);
        pulse(8'h12);
        ack_chk(44, "R12 source 4 outranks 1 after rotation");
        cfg_write(2'd3, 8'h00);
        ack_chk(41, "R12 source 1 served next");
        cfg_write(2'd3, 8'h00);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule